// File: doc/BRIEF.md
# Complex Constant Multiplier

This block multiplies a fixed-point complex sample by a complex coefficient that is fixed when the design is elaborated. The coefficient is supplied as two signed integers, `C_RE` and `C_IM`, with `C_FRAC` fractional bits. The input sample is a pair of words whose binary point is set by `IN_MSB` and `IN_LSB`. A flag selects whether those words are two's complement or unsigned. The results are two's complement words whose least significant bit has weight 2^`OUT_LSB`.

Each output is built from two partial products. Every partial product is generated by shift-and-add over the set bits of the coefficient magnitude, then negated when the coefficient is negative. Both partial products of one output, together with a single half-ulp constant, go into one exact wide sum. That sum is cut once to the output LSB, so the rounding error of each output stays within half an output ulp. A valid flag travels with the data. An optional register stage after the summation gives one cycle of latency.

Top module: `ccm_top`

## Requirements
- R1: `out_re` equals round(re·C_RE − im·C_IM) in output ulps. The input words carry weight 2^IN_LSB, the coefficients weight 2^−C_FRAC, and the output weight 2^OUT_LSB.
- R2: `out_im` equals round(im·C_RE + re·C_IM), using the same scaling and rounding as R1.
- R3: The rounding rule adds half an output ulp to the exact sum, then discards the DROP = OUT_LSB − IN_LSB + C_FRAC low bits. An exact tie therefore rounds toward positive infinity: +90.5 gives 91, and −90.5 gives −90.
- R4: The output width is OUT_W = IN_W + B + 2 − DROP, where IN_W = IN_MSB − IN_LSB + 1 and B = ceil(log2(max(|C_RE|,|C_IM|)+1)), with a minimum of 1. The defaults give 14 bits.
- R5: With `SIGNED_IN`=1 the input words are two's complement. With `SIGNED_IN`=0 the input words are unsigned. For example, 12'hFFF counts as −1 when signed and as 4095 when unsigned.
- R6: When both coefficient parts are zero, both outputs are always zero.
- R7: With `PIPE`=1, `out_valid` equals `in_valid` of the previous clock edge, and results appear one cycle after their inputs.
- R8: With `PIPE`=1, an edge with `in_valid` low leaves `out_re` and `out_im` unchanged.
- R9: A clock edge with `rst_n` low clears `out_valid`, `out_re` and `out_im` to zero. This holds even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | IN_W | Real part of the input sample |
| in_im | input | IN_W | Imaginary part of the input sample |
| out_valid | output | 1 | Result qualifier |
| out_re | output | OUT_W | Rounded real part of the product |
| out_im | output | OUT_W | Rounded imaginary part of the product |

## Verification
With the output register in place, both results and `out_valid` are due at the first rising edge after the sample is applied. The bench drives each sample on a falling edge and reads the outputs on the next falling edge, which is exactly one rising edge later. Hold and reset checks sample on the falling edge that follows the edge in question. Expected values come from a wide integer reference that uses the half-ulp-then-floor rule. The same reference is applied to a signed instance, an unsigned instance and a zero-coefficient instance.

// File: rtl/ccm_pkg.sv
// ccm_pkg: shared helpers for the complex constant multiplier.
// Assumes coefficients fit in a 32-bit signed int.
package ccm_pkg;

    // Magnitude of a signed integer coefficient.
    function automatic int ccm_abs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Bits needed to hold a non-negative magnitude, at least one.
    function automatic int ccm_bits(input int mag);
        int n;
        n = 0;
        while ((mag >> n) != 0) n++;
        return (n < 1) ? 1 : n;
    endfunction

    // Larger of two integers.
    function automatic int ccm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ccm_const_term.sv
// ccm_const_term: multiplies one input word by one elaborated constant
// using shift-and-add over the set bits of the constant magnitude.
// Assumes SUM_W is wide enough that the product never wraps.
module ccm_const_term import ccm_pkg::*; #(
    parameter int IN_W      = 12,
    parameter int SUM_W     = 22,
    parameter int COEF      = 1,
    parameter bit SIGNED_IN = 1'b1
) (
    input  logic [IN_W-1:0]  x,
    output logic [SUM_W-1:0] term
);
    localparam int MAG = ccm_abs(COEF);
    localparam int NB  = ccm_bits(MAG);

    logic [SUM_W-1:0] x_ext;
    logic [SUM_W-1:0] acc [NB+1];

    // Widen the input to the sum width, with sign or zero fill.
    generate
        if (SIGNED_IN) begin : g_sext
            assign x_ext = {{(SUM_W-IN_W){x[IN_W-1]}}, x};
        end else begin : g_zext
            assign x_ext = {{(SUM_W-IN_W){1'b0}}, x};
        end
    endgenerate

    assign acc[0] = '0;

    // One adder per set bit of the constant magnitude.
    generate
        for (genvar k = 0; k < NB; k++) begin : g_bit
            if (((MAG >> k) & 1) == 1) begin : g_add
                assign acc[k+1] = acc[k] + (x_ext << k);
            end else begin : g_skip
                assign acc[k+1] = acc[k];
            end
        end
    endgenerate

    // Apply the constant's sign.
    generate
        if (COEF < 0) begin : g_neg
            assign term = '0 - acc[NB];
        end else begin : g_pos
            assign term = acc[NB];
        end
    endgenerate

endmodule

// File: rtl/ccm_round_sum.sv
// ccm_round_sum: adds two exact partial products and a half-ulp constant
// in one sum, then keeps the bits above the DROP guard bits.
// Assumes 1 <= DROP < SUM_W.
module ccm_round_sum #(
    parameter int SUM_W = 22,
    parameter int DROP  = 8,
    parameter int OUT_W = SUM_W - DROP
) (
    input  logic [SUM_W-1:0] a,
    input  logic [SUM_W-1:0] b,
    output logic [OUT_W-1:0] y
);
    localparam logic [SUM_W-1:0] HALF_ULP = {{(SUM_W-1){1'b0}}, 1'b1} << (DROP-1);

    logic [SUM_W-1:0] total;

    // Single accumulation with the rounding constant, then truncation.
    assign total = a + b + HALF_ULP;
    assign y     = total[SUM_W-1:DROP];

endmodule

// File: rtl/ccm_out_stage.sv
// ccm_out_stage: optional register after the summation, holding the
// last accepted result while the input qualifier is low.
// Assumes synchronous active-low reset.
module ccm_out_stage #(
    parameter int W    = 14,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_in,
    input  logic [W-1:0] d_re,
    input  logic [W-1:0] d_im,
    output logic         v_out,
    output logic [W-1:0] q_re,
    output logic [W-1:0] q_im
);
    generate
        if (PIPE) begin : g_reg
            // Capture qualified results and track the qualifier.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_out <= 1'b0;
                    q_re  <= '0;
                    q_im  <= '0;
                end else begin
                    v_out <= v_in;
                    if (v_in) begin
                        q_re <= d_re;
                        q_im <= d_im;
                    end
                end
            end
        end else begin : g_wire
            assign v_out = v_in;
            assign q_re  = d_re;
            assign q_im  = d_im;
        end
    endgenerate

endmodule

// File: rtl/ccm_top.sv
// ccm_top: fixed-point complex sample times an elaborated complex constant.
// Each output sums two exact shift-add products and one half-ulp constant,
// then truncates to OUT_LSB. Assumes OUT_LSB > IN_LSB - C_FRAC.
module ccm_top import ccm_pkg::*; #(
    parameter int IN_MSB    = 3,
    parameter int IN_LSB    = -8,
    parameter int OUT_LSB   = -8,
    parameter int C_FRAC    = 8,
    parameter int C_RE      = 181,
    parameter int C_IM      = -75,
    parameter bit SIGNED_IN = 1'b1,
    parameter bit PIPE      = 1'b1,
    localparam int IN_W     = IN_MSB - IN_LSB + 1,
    localparam int DROP     = OUT_LSB - IN_LSB + C_FRAC,
    localparam int C_BITS   = ccm_bits(ccm_max(ccm_abs(C_RE), ccm_abs(C_IM))),
    localparam int SUM_W    = IN_W + C_BITS + 2,
    localparam int OUT_W    = SUM_W - DROP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_re,
    input  logic [IN_W-1:0]  in_im,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_re,
    output logic [OUT_W-1:0] out_im
);
    localparam bit ZERO_CONST = (C_RE == 0) && (C_IM == 0);

    logic [OUT_W-1:0] sum_re;
    logic [OUT_W-1:0] sum_im;

    generate
        if (ZERO_CONST) begin : g_zero
            assign sum_re = '0;
            assign sum_im = '0;
        end else begin : g_mult
            logic [SUM_W-1:0] p_rr, p_ii, p_ir, p_ri;

            ccm_const_term #(.IN_W(IN_W), .SUM_W(SUM_W), .COEF(C_RE), .SIGNED_IN(SIGNED_IN))
                u_rr (.x(in_re), .term(p_rr));
            ccm_const_term #(.IN_W(IN_W), .SUM_W(SUM_W), .COEF(-C_IM), .SIGNED_IN(SIGNED_IN))
                u_ii (.x(in_im), .term(p_ii));
            ccm_const_term #(.IN_W(IN_W), .SUM_W(SUM_W), .COEF(C_RE), .SIGNED_IN(SIGNED_IN))
                u_ir (.x(in_im), .term(p_ir));
            ccm_const_term #(.IN_W(IN_W), .SUM_W(SUM_W), .COEF(C_IM), .SIGNED_IN(SIGNED_IN))
                u_ri (.x(in_re), .term(p_ri));

            ccm_round_sum #(.SUM_W(SUM_W), .DROP(DROP), .OUT_W(OUT_W))
                u_sum_re (.a(p_rr), .b(p_ii), .y(sum_re));
            ccm_round_sum #(.SUM_W(SUM_W), .DROP(DROP), .OUT_W(OUT_W))
                u_sum_im (.a(p_ir), .b(p_ri), .y(sum_im));
        end
    endgenerate

    ccm_out_stage #(.W(OUT_W), .PIPE(PIPE)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (in_valid),
        .d_re  (sum_re),
        .d_im  (sum_im),
        .v_out (out_valid),
        .q_re  (out_re),
        .q_im  (out_im)
    );

endmodule

// File: rtl/ccm_checker.sv
// ccm_checker: temporal properties of ccm_top, attached by bind.
// Assumes the registered variant (PIPE=1); otherwise nothing is checked.
module ccm_checker #(
    parameter int W     = 12,
    parameter int OUT_W = 14,
    parameter bit PIPE  = 1'b1,
    parameter bit ZERO  = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     in_re,
    input logic [W-1:0]     in_im,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_re,
    input logic [OUT_W-1:0] out_im
);
    generate
        if (PIPE) begin : g_chk
            assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> out_valid == $past(in_valid));

            assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_re) && $stable(out_im)));

            assert_reset_clear_R9: assert property (@(posedge clk)
                !$past(rst_n) |-> (!out_valid && out_re == '0 && out_im == '0));

            // R1 and R2: a zero sample maps to a zero product.
            assert_zero_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(in_valid) && $past(in_re) == '0 && $past(in_im) == '0)
                |-> (out_re == '0 && out_im == '0));

            if (ZERO) begin : g_zero
                assert_zero_coef_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    out_re == '0 && out_im == '0);
            end
        end
    endgenerate
endmodule

bind ccm_top ccm_checker #(.W(IN_W), .OUT_W(OUT_W), .PIPE(PIPE), .ZERO(ZERO_CONST)) u_chk (.*);

// File: tb/tb_ccm_top.sv
module tb_ccm_top;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 12;
    localparam int OUT_W = 14;
    localparam int CR    = 181;
    localparam int CI    = -75;
    localparam int DROP  = 8;
    localparam int NVEC  = 10;
    localparam int VEC_RE [NVEC] = '{1, -1, 100, -300, 2047, -2048, 777, 0, 1234, -5};
    localparam int VEC_IM [NVEC] = '{0, 3, -200, 450, 2047, -2048, -1111, 9, 0, -2000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_re = '0, in_im = '0;
    logic vs, vu, vz;
    logic [OUT_W-1:0] s_re, s_im, u_re, u_im, z_re, z_im;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccm_top #(.C_RE(CR), .C_IM(CI), .SIGNED_IN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(vs), .out_re(s_re), .out_im(s_im));
    ccm_top #(.C_RE(CR), .C_IM(CI), .SIGNED_IN(1'b0)) dut_u (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(vu), .out_re(u_re), .out_im(u_im));
    ccm_top #(.C_RE(0), .C_IM(0), .SIGNED_IN(1'b1)) dut_z (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(vz), .out_re(z_re), .out_im(z_im));

    function automatic longint rnd(input longint exact);
        return (exact + (longint'(1) << (DROP-1))) >>> DROP;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one sample and compare all three instances one edge later.
    task automatic run_vec(input int a, input int b);
        longint ua, ub;
        @(negedge clk);
        in_re = IN_W'(a); in_im = IN_W'(b); in_valid = 1'b1;
        ua = longint'(in_re); ub = longint'(in_im);
        @(negedge clk);
        check("R7", vs, 1);
        check("R1", longint'($signed(s_re)), rnd(a * CR - b * CI));
        check("R2", longint'($signed(s_im)), rnd(b * CR + a * CI));
        check("R5", longint'($signed(u_re)), rnd(ua * CR - ub * CI));
        check("R5", longint'($signed(u_im)), rnd(ub * CR + ua * CI));
        check("R6", {z_re, z_im}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9: reset dominates a high in_valid.
        in_valid = 1'b1; in_re = 12'd500; in_im = 12'd7;
        repeat (3) @(negedge clk);
        check("R9", vs, 0);
        check("R9", s_re, 0);
        check("R9", s_im, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", vs, 0);
        check("R4", $bits(s_re), OUT_W);

        for (int i = 0; i < NVEC; i++) run_vec(VEC_RE[i], VEC_IM[i]);

        // R3: ties. 128*181/256 = 90.5 -> 91; 128*-75/256 = -37.5 -> -37.
        run_vec(128, 0);
        check("R3", longint'($signed(s_re)), 91);
        check("R3", longint'($signed(s_im)), -37);
        run_vec(-128, 0);
        check("R3", longint'($signed(s_re)), -90);
        check("R3", longint'($signed(s_im)), 38);

        // R5: all-ones word read as -1 signed, 4095 unsigned.
        run_vec(-1, 0);
        check("R5", longint'($signed(s_re)), rnd(-181));
        check("R5", longint'($signed(u_re)), rnd(4095 * 181));

        // R8: new data without in_valid leaves outputs unchanged.
        run_vec(300, -400);
        @(negedge clk);
        in_valid = 1'b0; in_re = 12'd1000; in_im = 12'd1000;
        @(negedge clk);
        check("R8", vs, 0);
        check("R8", longint'($signed(s_re)), rnd(300 * CR + 400 * CI));
        check("R8", longint'($signed(s_im)), rnd(-400 * CR + 300 * CI));

        // R9: reset mid-stream clears results.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", {vs, s_re, s_im}, 0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule